// File: doc/BRIEF.md
# Serial Fuse Word Programming Sequencer

This block carries out a single fuse-word program operation, and separately a full shadow-copy refresh, against a one-time-programmable fuse array. The array is reached through a simple strobe port. When a program request arrives, the sequencer first reads the word already stored at the target address. It then clears from the request every bit that is already blown. The remaining bits are walked out of a shift register, least significant bit first. A program strobe is issued only for bits that are one. After the program operation, the sequencer holds off new work for a fixed quiet gap.

All pulse lengths come from a 32-bit timing word, given as raw clock counts. That word is sampled when an operation is accepted. The program strobe length, the read strobe length and a relax count are packed into separate fields. A relax count of zero is stretched to one cycle, because an empty relax interval upsets a following shadow refresh.

A refresh request reads every fuse word in turn into a bank of shadow registers. A selection port makes any shadow word visible. The request clears itself when the last word has been copied. `busy` stays high for the whole program walk or refresh. During the post-write gap, `busy` is low and `gap_active` is high.

States:
- `S_IDLE`: waits for a request.
- Program path: `S_RD_PRE` (relax), then `S_RD_STB` (read strobe), then `S_RD_POST` (relax), then `S_BIT_SEL` (one visit per bit). From `S_BIT_SEL`, a one bit goes to `S_PG_STB` (program strobe) and then `S_PG_RLX` (relax). After the last bit the path goes to `S_GAP`, and from there back to `S_IDLE`.
- Refresh path: `S_RL_PRE`, then `S_RL_STB`, then `S_RL_POST`. This repeats once per word and then returns to `S_IDLE`.

Transitions:
- `S_IDLE` takes a program request first. It takes a refresh request only when no program request is present.
- Each timed state leaves once its count is spent.
- `S_BIT_SEL` with a zero bit shifts and stays in `S_BIT_SEL`, or goes to `S_GAP` after bit W-1.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, these outputs are low: `busy`, `gap_active`, `reload_active`, `fuse_prog` and `fuse_read`. Every shadow word reads zero.
- R2: `timing_cfg` is sampled when a request is accepted. The fields are:
  - bits 11:0: program strobe count P.
  - bits 15:12: relax count R.
  - bits 21:16: read strobe count S.
  - bits 31:22: ignored.
  
  A zero field acts as a count of one.
- R3: A program operation raises `fuse_read` at `prog_addr` for exactly S cycles before any program strobe. `fuse_rdata` is sampled in the last of those cycles.
- R4: The bits programmed are `prog_data & ~fuse_rdata`. Bits that are zero in that value receive no strobe, so the stored word becomes old | data.
- R5: Bits leave LSB first, in strictly increasing `fuse_bit` order. Each program strobe is high for exactly P cycles, with `fuse_bit` held stable throughout.
- R6: R relax cycles precede the read strobe, follow it, and follow each program strobe. One select cycle is spent per bit. `busy` is therefore high for exactly 2R+S+W+n(P+R) cycles, where n is the number of bits programmed.
- R7: When `busy` falls after a program operation, `gap_active` is high for exactly GAP_CYCLES cycles, during which `busy` stays low. Requests arriving during the gap are ignored.
- R8: `prog_start` and `reload_start` arriving while `busy` is high are ignored.
- R9: A refresh copies every fuse word into the shadow bank. Each word gets R cycles, then S read cycles, then R cycles. `busy` and `reload_active` are high for exactly NWORDS*(2R+S) cycles, after which both fall with no gap.
- R10: `fuse_prog` and `fuse_read` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | Program request pulse |
| prog_addr | input | AW | Fuse word address to program |
| prog_data | input | W | Bits requested to be blown |
| reload_start | input | 1 | Shadow refresh request pulse |
| timing_cfg | input | 32 | Packed strobe and relax counts |
| busy | output | 1 | Operation in progress |
| gap_active | output | 1 | Post-write quiet gap running |
| reload_active | output | 1 | Shadow refresh running |
| fuse_addr | output | AW | Fuse word address to the array |
| fuse_bit | output | BW | Bit index for a program strobe |
| fuse_prog | output | 1 | Program strobe |
| fuse_read | output | 1 | Read strobe |
| fuse_rdata | input | W | Word returned by the array during a read strobe |
| shadow_sel | input | AW | Shadow word selector |
| shadow_word | output | W | Selected shadow word |

## Verification
A wrong mask or shift-register state shows up at the fuse port within one bit slot. It appears as a strobe on an already-blown bit, a strobe on a bit requested as zero, or a bit index that goes backwards, and the final stored word differs from old | data. A wrong timer load or a wrong state transition changes the exact length of a `fuse_prog` or `fuse_read` pulse. It also changes the `busy` or `gap_active` duration, so the cycle totals are off by the end of the same operation. A faulty word counter or capture point in a refresh leaves a shadow word that differs from the array as soon as it is selected after `busy` falls.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    localparam int CW = 12;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_PRE,
        S_RD_STB,
        S_RD_POST,
        S_BIT_SEL,
        S_PG_STB,
        S_PG_RLX,
        S_GAP,
        S_RL_PRE,
        S_RL_STB,
        S_RL_POST
    } seq_state_t;

    typedef struct packed {
        logic [11:0] prog;
        logic [3:0]  relax;
        logic [5:0]  rd;
    } tcfg_t;

    // Unpack the timing word; zero fields are stretched to one cycle.
    function automatic tcfg_t decode_timing(input logic [31:0] w);
        tcfg_t t;
        t.prog  = (w[11:0]  == '0) ? 12'd1 : w[11:0];
        t.relax = (w[15:12] == '0) ? 4'd1  : w[15:12];
        t.rd    = (w[21:16] == '0) ? 6'd1  : w[21:16];
        return t;
    endfunction

endpackage

// File: rtl/fuse_seq_timer.sv
module fuse_seq_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fuse_seq_shifter.sv
module fuse_seq_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         mask_en,
    input  logic [W-1:0] mask_val,
    input  logic         step,
    output logic         lsb
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (mask_en) begin
            sreg <= sreg & ~mask_val;
        end else if (step) begin
            sreg <= {1'b0, sreg[W-1:1]};
        end
    end

    assign lsb = sreg[0];
endmodule

// File: rtl/fuse_seq_shadow.sv
module fuse_seq_shadow #(
    parameter int W      = 32,
    parameter int NWORDS = 8,
    localparam int AW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] sel,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[sel];
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
    import fuse_seq_pkg::*;
#(
    parameter int W          = 32,
    parameter int NWORDS     = 8,
    parameter int GAP_CYCLES = 500,
    localparam int AW        = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int BW        = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_start,
    input  logic [AW-1:0] prog_addr,
    input  logic [W-1:0]  prog_data,
    input  logic          reload_start,
    input  logic [31:0]   timing_cfg,
    output logic          busy,
    output logic          gap_active,
    output logic          reload_active,
    output logic [AW-1:0] fuse_addr,
    output logic [BW-1:0] fuse_bit,
    output logic          fuse_prog,
    output logic          fuse_read,
    input  logic [W-1:0]  fuse_rdata,
    input  logic [AW-1:0] shadow_sel,
    output logic [W-1:0]  shadow_word
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int TW = (GW > CW) ? GW : CW;

    seq_state_t    state, state_n;
    tcfg_t         cfg_q, cfg_use;
    logic [AW-1:0] addr_q, widx;
    logic [BW-1:0] bidx;

    logic          tz, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          take_prog, take_rl, mask_en, step, widx_inc, shadow_we;
    logic          bit_last, word_last;

    assign cfg_use   = (state == S_IDLE) ? decode_timing(timing_cfg) : cfg_q;
    assign bit_last  = (bidx == BW'(W - 1));
    assign word_last = (widx == AW'(NWORDS - 1));

    // Next-state and control decode
    always_comb begin
        state_n   = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        take_prog = 1'b0;
        take_rl   = 1'b0;
        mask_en   = 1'b0;
        step      = 1'b0;
        widx_inc  = 1'b0;
        shadow_we = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (prog_start) begin
                    take_prog = 1'b1;
                    state_n   = S_RD_PRE;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(cfg_use.relax) - TW'(1);
                end else if (reload_start) begin
                    take_rl  = 1'b1;
                    state_n  = S_RL_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_use.relax) - TW'(1);
                end
            end
            S_RD_PRE: if (tz) begin
                state_n  = S_RD_STB;
                tmr_load = 1'b1;
                tmr_val  = TW'(cfg_use.rd) - TW'(1);
            end
            S_RD_STB: if (tz) begin
                mask_en  = 1'b1;
                state_n  = S_RD_POST;
                tmr_load = 1'b1;
                tmr_val  = TW'(cfg_use.relax) - TW'(1);
            end
            S_RD_POST: if (tz) begin
                state_n = S_BIT_SEL;
            end
            S_BIT_SEL: begin
                if (lsb) begin
                    state_n  = S_PG_STB;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_use.prog) - TW'(1);
                end else begin
                    step = 1'b1;
                    if (bit_last) begin
                        state_n  = S_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(GAP_CYCLES - 1);
                    end
                end
            end
            S_PG_STB: if (tz) begin
                state_n  = S_PG_RLX;
                tmr_load = 1'b1;
                tmr_val  = TW'(cfg_use.relax) - TW'(1);
            end
            S_PG_RLX: if (tz) begin
                step = 1'b1;
                if (bit_last) begin
                    state_n  = S_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_CYCLES - 1);
                end else begin
                    state_n = S_BIT_SEL;
                end
            end
            S_GAP: if (tz) begin
                state_n = S_IDLE;
            end
            S_RL_PRE: if (tz) begin
                state_n  = S_RL_STB;
                tmr_load = 1'b1;
                tmr_val  = TW'(cfg_use.rd) - TW'(1);
            end
            S_RL_STB: if (tz) begin
                shadow_we = 1'b1;
                state_n   = S_RL_POST;
                tmr_load  = 1'b1;
                tmr_val   = TW'(cfg_use.relax) - TW'(1);
            end
            S_RL_POST: if (tz) begin
                if (word_last) begin
                    state_n = S_IDLE;
                end else begin
                    widx_inc = 1'b1;
                    state_n  = S_RL_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(cfg_use.relax) - TW'(1);
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cfg_q  <= '0;
            addr_q <= '0;
            widx   <= '0;
            bidx   <= '0;
        end else begin
            state <= state_n;
            if (take_prog || take_rl) cfg_q <= cfg_use;
            if (take_prog) begin
                addr_q <= prog_addr;
                bidx   <= '0;
            end else if (step && !bit_last) begin
                bidx <= bidx + BW'(1);
            end
            if (take_rl) widx <= '0;
            else if (widx_inc) widx <= widx + AW'(1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy          = 1'b0;
        gap_active    = 1'b0;
        reload_active = 1'b0;
        fuse_prog     = 1'b0;
        fuse_read     = 1'b0;
        fuse_addr     = addr_q;
        fuse_bit      = bidx;
        unique case (state)
            S_IDLE: ;
            S_GAP: gap_active = 1'b1;
            S_RD_PRE, S_RD_POST, S_BIT_SEL, S_PG_RLX: busy = 1'b1;
            S_RD_STB: begin
                busy      = 1'b1;
                fuse_read = 1'b1;
            end
            S_PG_STB: begin
                busy      = 1'b1;
                fuse_prog = 1'b1;
            end
            S_RL_PRE, S_RL_POST: begin
                busy          = 1'b1;
                reload_active = 1'b1;
                fuse_addr     = widx;
            end
            S_RL_STB: begin
                busy          = 1'b1;
                reload_active = 1'b1;
                fuse_read     = 1'b1;
                fuse_addr     = widx;
            end
            default: ;
        endcase
    end

    logic lsb;

    fuse_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tz)
    );

    fuse_seq_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_prog),
        .load_val (prog_data),
        .mask_en  (mask_en),
        .mask_val (fuse_rdata),
        .step     (step),
        .lsb      (lsb)
    );

    fuse_seq_shadow #(.W(W), .NWORDS(NWORDS)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (shadow_we),
        .widx  (widx),
        .wdata (fuse_rdata),
        .sel   (shadow_sel),
        .rdata (shadow_word)
    );
endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
    parameter int AW = 3,
    parameter int BW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_start,
    input logic          reload_start,
    input logic          busy,
    input logic          gap_active,
    input logic          reload_active,
    input logic          fuse_prog,
    input logic          fuse_read,
    input logic [BW-1:0] fuse_bit
);
    // R10
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_prog && fuse_read));

    // R10
    strobe_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_prog || fuse_read) |-> busy);

    // R7
    gap_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |-> !busy);

    // R7
    gap_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_active && (prog_start || reload_start)) |=> !busy);

    // R9
    reload_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_active |-> busy);

    // R5
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_prog && $past(fuse_prog)) |-> $stable(fuse_bit));

    // R5
    bit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fuse_prog) && busy && $past(busy)) |-> (fuse_bit >= $past(fuse_bit)));

    // R8
    busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_start || reload_start));
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_start    (prog_start),
    .reload_start  (reload_start),
    .busy          (busy),
    .gap_active    (gap_active),
    .reload_active (reload_active),
    .fuse_prog     (fuse_prog),
    .fuse_read     (fuse_read),
    .fuse_bit      (fuse_bit)
);

// File: tb/fuse_prog_seq_bench.sv
module fuse_prog_seq_bench;
    localparam int W      = 32;
    localparam int NWORDS = 8;
    localparam int GAP    = 500;
    localparam int AW     = 3;
    localparam int BW     = 5;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [W-1:0]  old;
        logic [W-1:0]  data;
        logic [11:0]   prog;
        logic [3:0]    relax;
        logic [5:0]    rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'h0000_0000, 32'h0000_0001, 12'd3, 4'd1, 6'd2},
        '{3'd2, 32'h0000_00F0, 32'h0000_0F3C, 12'd4, 4'd2, 6'd3},
        '{3'd3, 32'hFFFF_0000, 32'hFFFF_0000, 12'd5, 4'd1, 6'd1},
        '{3'd4, 32'h0000_0000, 32'h8000_0001, 12'd0, 4'd0, 6'd0},
        '{3'd7, 32'h1234_5678, 32'hA5A5_C3C3, 12'd2, 4'd3, 6'd4},
        '{3'd0, 32'h0000_0000, 32'h0000_0000, 12'd6, 4'd1, 6'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [W-1:0]  prog_data = '0;
    logic          reload_start = 1'b0;
    logic [31:0]   timing_cfg = '0;
    logic          busy, gap_active, reload_active, fuse_prog, fuse_read;
    logic [AW-1:0] fuse_addr;
    logic [BW-1:0] fuse_bit;
    logic [W-1:0]  fuse_rdata;
    logic [AW-1:0] shadow_sel = '0;
    logic [W-1:0]  shadow_word;

    always #2 clk = ~clk;

    fuse_prog_seq #(.W(W), .NWORDS(NWORDS), .GAP_CYCLES(GAP)) u_fuse_prog_seq (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .reload_start(reload_start), .timing_cfg(timing_cfg),
        .busy(busy), .gap_active(gap_active), .reload_active(reload_active),
        .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .fuse_prog(fuse_prog),
        .fuse_read(fuse_read), .fuse_rdata(fuse_rdata), .shadow_sel(shadow_sel),
        .shadow_word(shadow_word)
    );

    // Fuse array model and port monitors
    logic [W-1:0]  fuse_mem [NWORDS];
    logic          pre_en = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [W-1:0]  pre_val = '0;
    int edges = 0, prog_hi = 0, read_hi = 0, busy_cyc = 0, gap_cyc = 0;
    int rl_cyc = 0, busy_rises = 0, order_err = 0, prog_before_rd = 0;
    logic prev_prog = 1'b0, prev_busy = 1'b0, rd_seen = 1'b0, have_last = 1'b0;
    logic [BW-1:0] last_bit = '0;

    assign fuse_rdata = fuse_read ? fuse_mem[fuse_addr] : '0;

    initial for (int i = 0; i < NWORDS; i++) fuse_mem[i] = '0;

    always @(negedge clk) begin
        if (pre_en) fuse_mem[pre_addr] = pre_val;
        if (fuse_prog) begin
            fuse_mem[fuse_addr][fuse_bit] = 1'b1;
            prog_hi++;
        end
        if (fuse_prog && !prev_prog) begin
            edges++;
            if (have_last && fuse_bit <= last_bit) order_err++;
            if (!rd_seen) prog_before_rd++;
            last_bit  = fuse_bit;
            have_last = 1'b1;
        end
        if (fuse_read) begin
            read_hi++;
            rd_seen = 1'b1;
        end
        if (busy) busy_cyc++;
        if (gap_active) gap_cyc++;
        if (reload_active) rl_cyc++;
        if (busy && !prev_busy) busy_rises++;
        if (!busy) begin
            rd_seen   = 1'b0;
            have_last = 1'b0;
        end
        prev_prog = fuse_prog;
        prev_busy = busy;
    end

    int checks = 0, errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [W-1:0] v);
        pre_addr = a;
        pre_val  = v;
        pre_en   = 1'b1;
        @(negedge clk);
        #1 pre_en = 1'b0;
    endtask

    task automatic pulse_prog(input logic [AW-1:0] a, input logic [W-1:0] d);
        prog_addr  = a;
        prog_data  = d;
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic pulse_reload();
        reload_start = 1'b1;
        @(negedge clk);
        reload_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((busy || gap_active) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 20000, "R6 operation completes", n, 20000);
    endtask

    function automatic logic [31:0] tword(input logic [11:0] p, input logic [3:0] r,
                                          input logic [5:0] s);
        return {4'h0, 6'h2A, s, r, p};
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!busy && !gap_active && !reload_active, "R1 status low after reset",
            {busy, gap_active, reload_active}, 0);
        chk(!fuse_prog && !fuse_read, "R1 strobes low after reset", {fuse_prog, fuse_read}, 0);
        #1;
        chk(shadow_word == '0, "R1 shadow zero after reset", shadow_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2..R7
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            int pp = (t.prog == 0) ? 1 : int'(t.prog);
            int rr = (t.relax == 0) ? 1 : int'(t.relax);
            int ss = (t.rd == 0) ? 1 : int'(t.rd);
            logic [W-1:0] m = t.data & ~t.old;
            int n = $countones(m);
            int e0, p0, r0, b0, g0, o0, x0;
            preload(t.addr, t.old);
            e0 = edges; p0 = prog_hi; r0 = read_hi; b0 = busy_cyc; g0 = gap_cyc;
            o0 = order_err; x0 = prog_before_rd;
            timing_cfg = tword(t.prog, t.relax, t.rd);
            pulse_prog(t.addr, t.data);
            timing_cfg = 32'hFFFF_FFFF; // R2: later changes must not matter
            wait_idle();
            chk(fuse_mem[t.addr] == (t.old | t.data), "R4 stored word", fuse_mem[t.addr],
                t.old | t.data);
            chk(edges - e0 == n, "R4 strobe count", edges - e0, n);
            chk(prog_hi - p0 == n * pp, "R5 program strobe length", prog_hi - p0, n * pp);
            chk(order_err == o0, "R5 LSB-first order", order_err - o0, 0);
            chk(read_hi - r0 == ss, "R3 read strobe length", read_hi - r0, ss);
            chk(prog_before_rd == x0, "R3 read before program", prog_before_rd - x0, 0);
            chk(busy_cyc - b0 == 2 * rr + ss + W + n * (pp + rr), "R6 R2 busy duration",
                busy_cyc - b0, 2 * rr + ss + W + n * (pp + rr));
            chk(gap_cyc - g0 == GAP, "R7 gap length", gap_cyc - g0, GAP);
        end

        // R8: requests during busy are ignored
        begin
            int b0, l0;
            preload(3'd5, 32'h0);
            preload(3'd6, 32'h0);
            b0 = busy_rises; l0 = rl_cyc;
            timing_cfg = tword(12'd3, 4'd1, 6'd2);
            pulse_prog(3'd5, 32'h0000_000F);
            repeat (5) @(negedge clk);
            prog_addr = 3'd6; prog_data = 32'h0000_FFFF;
            prog_start = 1'b1; reload_start = 1'b1;
            @(negedge clk);
            prog_start = 1'b0; reload_start = 1'b0;
            wait_idle();
            chk(fuse_mem[6] == 32'h0, "R8 busy start ignored", fuse_mem[6], 0);
            chk(busy_rises - b0 == 1, "R8 single operation", busy_rises - b0, 1);
            chk(rl_cyc == l0, "R8 busy reload ignored", rl_cyc - l0, 0);
            chk(fuse_mem[5] == 32'h0000_000F, "R4 first word programmed", fuse_mem[5], 32'hF);
        end

        // R7: requests during the gap are ignored
        begin
            int b0, n;
            b0 = busy_rises;
            pulse_prog(3'd5, 32'h0000_0030);
            n = 0;
            while (!gap_active && n < 5000) begin
                @(negedge clk);
                n++;
            end
            repeat (3) @(negedge clk);
            prog_addr = 3'd6; prog_data = 32'h0000_0001; prog_start = 1'b1;
            @(negedge clk);
            prog_start = 1'b0;
            wait_idle();
            repeat (2) @(negedge clk);
            chk(busy_rises - b0 == 1, "R7 gap start ignored", busy_rises - b0, 1);
            chk(fuse_mem[6] == 32'h0, "R7 gap start no program", fuse_mem[6], 0);
        end

        // R9: shadow refresh
        begin
            int b0, l0, g0, r0;
            for (int i = 0; i < NWORDS; i++) preload(AW'(i), 32'hC0DE_0000 ^ (i * 32'h0101_1011));
            b0 = busy_cyc; l0 = rl_cyc; g0 = gap_cyc; r0 = read_hi;
            timing_cfg = tword(12'd7, 4'd2, 6'd3);
            pulse_reload();
            wait_idle();
            chk(busy_cyc - b0 == NWORDS * 7, "R9 refresh busy length", busy_cyc - b0, NWORDS * 7);
            chk(rl_cyc - l0 == NWORDS * 7, "R9 refresh active length", rl_cyc - l0, NWORDS * 7);
            chk(gap_cyc == g0, "R9 no gap after refresh", gap_cyc - g0, 0);
            chk(read_hi - r0 == NWORDS * 3, "R9 read strobes", read_hi - r0, NWORDS * 3);
            for (int i = 0; i < NWORDS; i++) begin
                shadow_sel = AW'(i);
                #1;
                chk(shadow_word == fuse_mem[i], "R9 shadow copy", shadow_word, fuse_mem[i]);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule